// File: doc/BRIEF.md
# Inversion-Steered 32-bit ALU

A purely combinational arithmetic-logic unit for a single-cycle integer datapath. Each operand can be complemented before use, one flag per operand, and a 2-bit selector then picks one of four result paths: bitwise AND, bitwise OR, adder sum, or a set-if-less bit. Six operations come from this small control word. Subtract reuses the adder with operand B complemented. Nor reuses the AND path with both operands complemented.

The adder is a ripple chain, and its carry-in is tied to the B-invert flag, so complementing B also adds the missing one. The unit reports three things: the selected result, a zero flag that a branch-on-equal decision can use, and a signed-overflow flag that the surrounding pipeline treats as an exception. The overflow flag is only meaningful for the sum path.

Control encodings used by the rest of the datapath:

| Operation | a_inv_i | b_inv_i | op_sel_i |
|-----------|---------|---------|----------|
| and | 0 | 0 | 00 |
| or | 0 | 0 | 01 |
| add | 0 | 0 | 10 |
| sub | 0 | 1 | 10 |
| slt | 0 | 1 | 11 |
| nor | 1 | 1 | 00 |

Top module: `alu_inv32`

## Requirements
- R1: With op_sel_i=00, result_o is the bitwise AND of the two conditioned operands. A conditioned operand is the input, bitwise complemented when its invert flag is 1.
- R2: With op_sel_i=01, result_o is the bitwise OR of the two conditioned operands.
- R3: With op_sel_i=10, result_o is the 32-bit sum of the conditioned operands plus a carry-in equal to b_inv_i. With a_inv_i=0 and b_inv_i=1 this is a_i minus b_i, modulo 2^32.
- R4: With a_inv_i=1, b_inv_i=1 and op_sel_i=00, result_o is the bitwise NOR of a_i and b_i.
- R5: With op_sel_i=11, result_o[31:1] is 0 and result_o[0] is the sign of the exact, unbounded value of the conditioned sum. With a_inv_i=0 and b_inv_i=1 this means result_o=1 exactly when a_i is less than b_i as signed numbers, even when the 32-bit difference overflows.
- R6: zero_o is 1 exactly when result_o is all zeros, whatever operation is selected.
- R7: With op_sel_i=10, ovf_o is 1 exactly when the two conditioned operands have equal sign bits and the sign bit of result_o differs from them.
- R8: ovf_o is 0 whenever op_sel_i is 00, 01 or 11, even if the internal adder overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| a_inv_i | input | 1 | Complement operand A before use |
| b_inv_i | input | 1 | Complement operand B before use; also the adder carry-in |
| op_sel_i | input | 2 | Result path: 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow on the sum path |

## Verification
Two functions can be active for the same operand pair: the set-if-less decision and adder overflow. When the subtraction wraps, the less bit has to come from the corrected sign, and the overflow flag still has to stay low because the sum path is not selected. The bench forces this case with pairs such as 0x80000000 against 1 and 0x7FFFFFFF against -1. It runs each pair once as slt and once as sub. The slt run must give the true signed order with ovf_o low. The sub run must raise ovf_o. Equal operands under sub exercise the zero flag together with a non-overflowing difference.

// File: rtl/alu_inv_pkg.sv
package alu_inv_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } op_sel_e;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] data_i,
  input  logic         inv_i,
  output logic [W-1:0] data_o
);
  assign data_o = data_i ^ {W{inv_i}};

  always_comb begin
    if (inv_i) begin
      p_cond_inv_r4: assert ((data_o & data_i) == '0)
        else $error("conditioned operand not complemented");
    end
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1]   = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  // signed overflow: carry into MSB differs from carry out of MSB
  assign ovf_o = carry[W] ^ carry[W-1];

  always_comb begin
    p_sum_ok_r3: assert ({carry[W], sum_o} ==
                         ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("ripple sum mismatch");
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_inv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_c_i,
  input  logic [W-1:0] b_c_i,
  input  logic [W-1:0] sum_i,
  input  logic         less_i,
  input  op_sel_e      op_i,
  output logic [W-1:0] result_o
);
  logic [W-1:0] and_w;
  logic [W-1:0] or_w;
  logic [W-1:0] less_w;

  assign and_w  = a_c_i & b_c_i;
  assign or_w   = a_c_i | b_c_i;
  assign less_w = {{(W-1){1'b0}}, less_i};

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = and_w;
      OP_OR:   result_o = or_w;
      OP_SUM:  result_o = sum_i;
      OP_LESS: result_o = less_w;
      default: result_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_AND) begin
      p_and_subset_r1: assert (((result_o & ~a_c_i) == '0) && ((result_o & ~b_c_i) == '0))
        else $error("and result has bits outside operands");
    end
    if (op_i == OP_OR) begin
      p_or_cover_r2: assert (((result_o & a_c_i) == a_c_i) && ((result_o & b_c_i) == b_c_i))
        else $error("or result misses operand bits");
    end
    if (op_i == OP_LESS) begin
      p_less_bool_r5: assert (result_o[W-1:1] == '0)
        else $error("less result not boolean");
    end
  end
endmodule

// File: rtl/alu_inv32.sv
module alu_inv32
  import alu_inv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_inv_i,
  input  logic         b_inv_i,
  input  logic [1:0]   op_sel_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;

  op_sel_e      op;
  logic [W-1:0] a_c;
  logic [W-1:0] b_c;
  logic [W-1:0] sum;
  logic         add_ovf;
  logic         less;

  assign op = op_sel_e'(op_sel_i);

  alu_operand_cond #(.W(W)) u_cond_a (.data_i(a_i), .inv_i(a_inv_i), .data_o(a_c));
  alu_operand_cond #(.W(W)) u_cond_b (.data_i(b_i), .inv_i(b_inv_i), .data_o(b_c));

  // carry-in follows B inversion: A + ~B + 1 = A - B
  alu_ripple_add #(.W(W)) u_add (
    .a_i   (a_c),
    .b_i   (b_c),
    .cin_i (b_inv_i),
    .sum_o (sum),
    .ovf_o (add_ovf)
  );

  // true sign of the sum, corrected when it wrapped
  assign less = sum[MSB] ^ add_ovf;

  alu_result_mux #(.W(W)) u_mux (
    .a_c_i    (a_c),
    .b_c_i    (b_c),
    .sum_i    (sum),
    .less_i   (less),
    .op_i     (op),
    .result_o (result_o)
  );

  assign zero_o = ~|result_o;
  assign ovf_o  = (op == OP_SUM) & add_ovf;

  always_comb begin
    p_zero_flag_r6: assert (zero_o == ($countones(result_o) == 0))
      else $error("zero flag disagrees with result");
    if (op != OP_SUM) begin
      p_no_overflow_r8: assert (!ovf_o) else $error("overflow outside sum path");
    end
    if (ovf_o) begin
      p_ovf_sign_r7: assert ((a_c[MSB] == b_c[MSB]) && (result_o[MSB] != a_c[MSB]))
        else $error("overflow without sign violation");
    end
    if (a_inv_i && b_inv_i && op == OP_AND) begin
      p_nor_r4: assert (result_o == ~(a_i | b_i)) else $error("nor mismatch");
    end
    if (!a_inv_i && b_inv_i && op == OP_LESS) begin
      p_slt_order_r5: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("slt order mismatch");
    end
  end
endmodule

// File: tb/alu_inv32_tb_top.sv
module alu_inv32_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         ainv, binv;
  logic [1:0]   op;
  logic [W-1:0] res;
  logic         zero, ovf;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done  = 0;

  always #5 clk = ~clk;

  alu_inv32 #(.W(W)) dut_i (
    .a_i(a), .b_i(b), .a_inv_i(ainv), .b_inv_i(binv), .op_sel_i(op),
    .result_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  // reference built from the requirement text, widened arithmetic
  task automatic chk(input string req, input logic [W-1:0] ta, input logic [W-1:0] tb,
                     input logic ti_a, input logic ti_b, input logic [1:0] top);
    logic [W-1:0] ac, bc, er;
    logic signed [W+1:0] wide;
    logic eo;
    @(posedge clk);
    a = ta; b = tb; ainv = ti_a; binv = ti_b; op = top;
    @(negedge clk);
    ac = ti_a ? ~ta : ta;
    bc = ti_b ? ~tb : tb;
    wide = $signed({{2{ac[W-1]}}, ac}) + $signed({{2{bc[W-1]}}, bc}) + $signed({{(W+1){1'b0}}, ti_b});
    eo = 1'b0;
    case (top)
      2'b00: er = ac & bc;
      2'b01: er = ac | bc;
      2'b10: begin
        er = wide[W-1:0];
        eo = (wide > $signed({2'b00, 1'b0, {(W-1){1'b1}}})) ||
             (wide < -$signed({2'b00, 1'b1, {(W-1){1'b0}}}));
      end
      default: er = {{(W-1){1'b0}}, wide[W+1]};
    endcase
    n_chk++;
    if (res !== er || zero !== (er == '0) || ovf !== eo) begin
      n_err++;
      $display("FAIL %s a=%h b=%h ctl=%b%b%b: got res=%h z=%b v=%b exp res=%h z=%b v=%b",
               req, ta, tb, ti_a, ti_b, top, res, zero, ovf, er, (er == '0), eo);
    end
  endtask

  task automatic t_idle;      // all-zero control and operands
    chk("R6", '0, '0, 0, 0, 2'b00);
  endtask

  task automatic t_and;
    chk("R1", 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 2'b00);
    chk("R1", 32'hFFFF_FFFF, 32'h8000_0001, 0, 0, 2'b00);
    chk("R1", 32'h0F0F_0000, 32'hF0F0_FFFF, 1, 0, 2'b00);
  endtask

  task automatic t_or;
    chk("R2", 32'h0000_00F0, 32'h0F00_000F, 0, 0, 2'b01);
    chk("R2", 32'h0, 32'h0, 0, 0, 2'b01);
    chk("R2", 32'h1234_5678, 32'hFFFF_0000, 0, 1, 2'b01);
  endtask

  task automatic t_add;
    chk("R3", 32'd100, 32'd23, 0, 0, 2'b10);
    chk("R3", 32'hFFFF_FFFF, 32'd1, 0, 0, 2'b10);
    chk("R7", 32'h7FFF_FFFF, 32'd1, 0, 0, 2'b10);
    chk("R7", 32'h8000_0000, 32'h8000_0000, 0, 0, 2'b10);
  endtask

  task automatic t_sub;
    chk("R3", 32'd50, 32'd8, 0, 1, 2'b10);
    chk("R3", 32'd3, 32'd9, 0, 1, 2'b10);
    chk("R6", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 1, 2'b10);
    chk("R7", 32'h8000_0000, 32'd1, 0, 1, 2'b10);
    chk("R7", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, 2'b10);
    chk("R7", 32'h0, 32'h8000_0000, 0, 1, 2'b10);
  endtask

  task automatic t_slt;
    chk("R5", 32'd3, 32'd9, 0, 1, 2'b11);
    chk("R5", 32'd9, 32'd3, 0, 1, 2'b11);
    chk("R5", 32'hFFFF_FFFF, 32'd0, 0, 1, 2'b11);
    chk("R5", 32'd5, 32'd5, 0, 1, 2'b11);
    // wrapping difference: less must stay right, overflow low (R8)
    chk("R8", 32'h8000_0000, 32'd1, 0, 1, 2'b11);
    chk("R8", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, 2'b11);
  endtask

  task automatic t_nor;
    chk("R4", 32'h0, 32'h0, 1, 1, 2'b00);
    chk("R4", 32'hFF00_FF00, 32'h00F0_00F0, 1, 1, 2'b00);
    chk("R4", 32'hFFFF_FFFF, 32'h0, 1, 1, 2'b00);
  endtask

  task automatic t_no_ovf;   // adder overflows internally, path not selected
    chk("R8", 32'h7FFF_FFFF, 32'd1, 0, 0, 2'b00);
    chk("R8", 32'h7FFF_FFFF, 32'd1, 0, 0, 2'b01);
    chk("R8", 32'h8000_0000, 32'h8000_0000, 1, 1, 2'b01);
  endtask

  task automatic t_corners;
    logic [W-1:0] cv [4];
    logic [1:0] ctl_op [6];
    logic ctl_a [6];
    logic ctl_b [6];
    cv[0] = 32'h0; cv[1] = 32'hFFFF_FFFF; cv[2] = 32'h8000_0000; cv[3] = 32'h7FFF_FFFF;
    ctl_a = '{0, 0, 0, 0, 0, 1};
    ctl_b = '{0, 1, 0, 0, 1, 1};
    ctl_op = '{2'b10, 2'b10, 2'b00, 2'b01, 2'b11, 2'b00};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 6; k++)
          chk("R3/R5/R7 corner", cv[i], cv[j], ctl_a[k], ctl_b[k], ctl_op[k]);
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++)
      chk("R1 R2 R3 R5 random", $urandom, $urandom, 1'($urandom), 1'($urandom), 2'($urandom));
  endtask

  initial begin
    a = '0; b = '0; ainv = 0; binv = 0; op = 2'b00;
    t_idle;
    t_and;
    t_or;
    t_add;
    t_sub;
    t_slt;
    t_nor;
    t_no_ovf;
    t_corners;
    t_random;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule